// File: doc/BRIEF.md
# Integer Execute Unit with Overflow and Illegal-Operation Traps

This block is the combinational integer execute stage of a 32-bit load/store core. Each cycle it takes an operation code from the decoder, two register operands (`opa` from the first source register, `opb` from the second), a raw 16-bit immediate field and a 5-bit constant shift amount. In the same cycle it produces a result word, a write-enable for the destination register, a branch-taken flag, and two trap flags: one for signed arithmetic overflow and one for an operation code it does not know.

The unit does addition and subtraction in a trapping and a wrapping form, bitwise logic with register or immediate operands, load-upper-immediate, signed and unsigned set-less-than, and left, logical-right and arithmetic-right shifts by a constant or by a register. It also evaluates the six branch conditions. The surrounding pipeline uses the two trap flags to start exception handling and the taken flag to redirect fetch. It writes back only when `wr_en` is high. Whenever `wr_en` is low the result word is forced to zero.

Top module: `int_exec_unit`

## Requirements
- R1: For ADD (code 1) and ADDI (code 5, `imm` sign-extended), `ovf_trap` is 1 and `wr_en` is 0 when the two addends have the same sign and the sign of the sum differs from theirs. Otherwise `wr_en` is 1 and `result` is the 32-bit sum.
- R2: For SUB (code 3, `opa - opb`), `ovf_trap` is 1 and `wr_en` is 0 when the operands differ in sign and the sign of the difference differs from the sign of `opa`. Otherwise `wr_en` is 1 and `result` is the difference.
- R3: ADDU (code 2), SUBU (code 4) and ADDIU (code 6, `imm` sign-extended) write the sum or difference modulo 2^32 and never raise `ovf_trap`.
- R4: AND (7), OR (8), XOR (9) and NOR (10) write the bitwise function of `opa` and `opb`. NOR is the complement of the OR.
- R5: ANDI (11), ORI (12) and XORI (13) combine `opa` with `imm` zero-extended to 32 bits.
- R6: LUI (14) writes `imm` into bits 31:16 and zeros into bits 15:0.
- R7: SLT (15) compares `opa` and `opb` as signed numbers and SLTU (16) compares them as unsigned numbers. SLTI (17) compares `opa` signed against the sign-extended `imm`. SLTIU (18) compares `opa` unsigned against the sign-extended `imm` taken as an unsigned word. Each writes 1 when `opa` is less, otherwise 0.
- R8: SLL (19), SRL (20) and SRA (21) shift `opb` by `shamt`. SRL fills with zeros and SRA fills with copies of bit 31.
- R9: SLLV (22), SRLV (23) and SRAV (24) shift `opb` by `opa[4:0]` and ignore the upper bits of `opa`.
- R10: BEQ (25) and BNE (26) compare `opa` with `opb`. BGTZ (27), BLEZ (28), BGEZ (29) and BLTZ (30) test `opa` as a signed number against zero. For these codes `br_taken` reports the condition, and `wr_en` and `result` are 0.
- R11: Any other code, including 0 and 31 to 63, sets `illegal_op` to 1 with `wr_en`, `ovf_trap`, `br_taken` and `result` at 0. At most one of `wr_en`, `ovf_trap` and `illegal_op` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Decoded operation code |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Raw immediate field |
| shamt | input | 5 | Constant shift amount |
| result | output | 32 | Result word, zero when wr_en is low |
| wr_en | output | 1 | Destination register write enable |
| ovf_trap | output | 1 | Signed overflow exception |
| illegal_op | output | 1 | Unknown operation code |
| br_taken | output | 1 | Branch condition holds |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path and a 16-bit immediate. With these values the sign bit sits at bit 31, and the immediate extension boundary falls at bit 15 with bits 31:16 as the place where LUI lands. The vectors probe that boundary through 0x7FFF and 0x8000 immediates, overflow at the most positive and most negative words, and shift amounts of 0 and 31. They also cover register shift amounts whose bits above bit 4 are set, and the unknown codes 0 and 63 at the two ends of the code space.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPW = 6;

  localparam logic [OPW-1:0] OP_ADD   = 6'd1;
  localparam logic [OPW-1:0] OP_ADDU  = 6'd2;
  localparam logic [OPW-1:0] OP_SUB   = 6'd3;
  localparam logic [OPW-1:0] OP_SUBU  = 6'd4;
  localparam logic [OPW-1:0] OP_ADDI  = 6'd5;
  localparam logic [OPW-1:0] OP_ADDIU = 6'd6;
  localparam logic [OPW-1:0] OP_AND   = 6'd7;
  localparam logic [OPW-1:0] OP_OR    = 6'd8;
  localparam logic [OPW-1:0] OP_XOR   = 6'd9;
  localparam logic [OPW-1:0] OP_NOR   = 6'd10;
  localparam logic [OPW-1:0] OP_ANDI  = 6'd11;
  localparam logic [OPW-1:0] OP_ORI   = 6'd12;
  localparam logic [OPW-1:0] OP_XORI  = 6'd13;
  localparam logic [OPW-1:0] OP_LUI   = 6'd14;
  localparam logic [OPW-1:0] OP_SLT   = 6'd15;
  localparam logic [OPW-1:0] OP_SLTU  = 6'd16;
  localparam logic [OPW-1:0] OP_SLTI  = 6'd17;
  localparam logic [OPW-1:0] OP_SLTIU = 6'd18;
  localparam logic [OPW-1:0] OP_SLL   = 6'd19;
  localparam logic [OPW-1:0] OP_SRL   = 6'd20;
  localparam logic [OPW-1:0] OP_SRA   = 6'd21;
  localparam logic [OPW-1:0] OP_SLLV  = 6'd22;
  localparam logic [OPW-1:0] OP_SRLV  = 6'd23;
  localparam logic [OPW-1:0] OP_SRAV  = 6'd24;
  localparam logic [OPW-1:0] OP_BEQ   = 6'd25;
  localparam logic [OPW-1:0] OP_BNE   = 6'd26;
  localparam logic [OPW-1:0] OP_BGTZ  = 6'd27;
  localparam logic [OPW-1:0] OP_BLEZ  = 6'd28;
  localparam logic [OPW-1:0] OP_BGEZ  = 6'd29;
  localparam logic [OPW-1:0] OP_BLTZ  = 6'd30;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_ARITH, RSEL_LOGIC, RSEL_SHIFT, RSEL_LESS, RSEL_UPPER
  } rsel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_e;
  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} shift_e;
  typedef enum logic [2:0] {
    BC_EQ, BC_NE, BC_GTZ, BC_LEZ, BC_GEZ, BC_LTZ
  } bcond_e;
endpackage

// File: rtl/exu_arith.sv
module exu_arith #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            do_sub,
  output logic [XLEN-1:0] sum,
  output logic            ovf_evt
);
  localparam int MSB = XLEN - 1;

  function automatic logic [XLEN-1:0] add_sub(input logic [XLEN-1:0] x,
                                               input logic [XLEN-1:0] y,
                                               input logic s);
    logic [XLEN-1:0] yy;
    yy = s ? ~y : y;
    return x + yy + {{(XLEN-1){1'b0}}, s};
  endfunction

  function automatic logic sign_ovf(input logic xs, input logic ys,
                                    input logic rs, input logic s);
    logic ye;
    ye = s ? ~ys : ys;
    return (xs == ye) && (rs != xs);
  endfunction

  assign sum     = add_sub(a, b, do_sub);
  assign ovf_evt = sign_ovf(a[MSB], b[MSB], sum[MSB], do_sub);

  always_comb begin
    AST_OVF_SIGN: assert (!ovf_evt || (sum[MSB] != a[MSB])); // R1
    AST_SUB_OVF_MIX: assert (!(ovf_evt && do_sub) || (a[MSB] != b[MSB])); // R2
  end
endmodule

// File: rtl/exu_logic.sv
module exu_logic #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]       a,
  input  logic [XLEN-1:0]       b,
  input  exu_pkg::logic_e       fn,
  output logic [XLEN-1:0]       y
);
  import exu_pkg::*;

  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

  always_comb begin
    AST_AND_SUBSET: assert (fn != LG_AND || (y & ~a) == '0); // R4
    AST_NOR_DISJOINT: assert (fn != LG_NOR || (y & a) == '0); // R4
  end
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
  parameter int XLEN = 32,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  val,
  input  logic [SHW-1:0]   amt,
  input  exu_pkg::shift_e  kind,
  output logic [XLEN-1:0]  y
);
  import exu_pkg::*;
  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] stage [SHW+1];
  logic            fill;

  assign fill     = (kind == SH_RARI) ? val[MSB] : 1'b0;
  assign stage[0] = val;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    always_comb begin
      if (!amt[k])
        stage[k+1] = stage[k];
      else if (kind == SH_LEFT)
        stage[k+1] = {stage[k][XLEN-1-D:0], {D{1'b0}}};
      else
        stage[k+1] = {{D{fill}}, stage[k][XLEN-1:D]};
    end
  end

  assign y = stage[SHW];

  always_comb begin
    AST_SRA_SIGN: assert (kind != SH_RARI || y[MSB] == val[MSB]); // R8
    AST_SRL_ZERO: assert (kind != SH_RLOG || amt == '0 || !y[MSB]); // R8
    AST_SLL_ZERO: assert (kind != SH_LEFT || amt == '0 || !y[0]); // R8
  end
endmodule

// File: rtl/exu_branch.sv
module exu_branch #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  exu_pkg::bcond_e  cond,
  output logic             taken
);
  import exu_pkg::*;
  localparam int MSB = XLEN - 1;

  logic is_zero, is_neg, same;
  assign is_zero = (a == '0);
  assign is_neg  = a[MSB];
  assign same    = ((a ^ b) == '0);

  always_comb begin
    unique case (cond)
      BC_EQ:   taken = same;
      BC_NE:   taken = !same;
      BC_GTZ:  taken = !is_neg && !is_zero;
      BC_LEZ:  taken = is_neg || is_zero;
      BC_GEZ:  taken = !is_neg;
      default: taken = is_neg;
    endcase
  end

  always_comb begin
    AST_GTZ_NONZERO: assert (cond != BC_GTZ || !taken || a != '0); // R10
    AST_LTZ_NEG: assert (cond != BC_LTZ || !taken || $signed(a) < 0); // R10
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
  parameter int XLEN = 32,
  parameter int IMMW = 16,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [exu_pkg::OPW-1:0] op_code,
  input  logic [XLEN-1:0]         opa,
  input  logic [XLEN-1:0]         opb,
  input  logic [IMMW-1:0]         imm,
  input  logic [SHW-1:0]          shamt,
  output logic [XLEN-1:0]         result,
  output logic                    wr_en,
  output logic                    ovf_trap,
  output logic                    illegal_op,
  output logic                    br_taken
);
  import exu_pkg::*;
  localparam int EXTW = XLEN - IMMW;

  function automatic logic [XLEN-1:0] imm_sext(input logic [IMMW-1:0] v);
    return {{EXTW{v[IMMW-1]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] imm_zext(input logic [IMMW-1:0] v);
    return {{EXTW{1'b0}}, v};
  endfunction

  function automatic logic less_than(input logic [XLEN-1:0] x,
                                     input logic [XLEN-1:0] y,
                                     input logic signed_cmp);
    logic [XLEN-1:0] xf, yf;
    xf = x;
    yf = y;
    if (signed_cmp) begin
      xf[XLEN-1] = ~x[XLEN-1];
      yf[XLEN-1] = ~y[XLEN-1];
    end
    return xf < yf;
  endfunction

  // decode controls
  rsel_e    rsel;
  logic_e   lfn;
  shift_e   skind;
  bcond_e   bcond;
  logic     do_sub, use_simm, use_zimm, trap_en, we_dec, ill_dec, is_br;
  logic     var_sh, cmp_signed;

  always_comb begin
    rsel = RSEL_NONE; lfn = LG_AND; skind = SH_LEFT; bcond = BC_EQ;
    do_sub = 1'b0; use_simm = 1'b0; use_zimm = 1'b0; trap_en = 1'b0;
    we_dec = 1'b1; ill_dec = 1'b0; is_br = 1'b0; var_sh = 1'b0;
    cmp_signed = 1'b0;
    case (op_code)
      OP_ADD:   begin rsel = RSEL_ARITH; trap_en = 1'b1; end
      OP_ADDU:  rsel = RSEL_ARITH;
      OP_SUB:   begin rsel = RSEL_ARITH; do_sub = 1'b1; trap_en = 1'b1; end
      OP_SUBU:  begin rsel = RSEL_ARITH; do_sub = 1'b1; end
      OP_ADDI:  begin rsel = RSEL_ARITH; use_simm = 1'b1; trap_en = 1'b1; end
      OP_ADDIU: begin rsel = RSEL_ARITH; use_simm = 1'b1; end
      OP_AND:   begin rsel = RSEL_LOGIC; lfn = LG_AND; end
      OP_OR:    begin rsel = RSEL_LOGIC; lfn = LG_OR;  end
      OP_XOR:   begin rsel = RSEL_LOGIC; lfn = LG_XOR; end
      OP_NOR:   begin rsel = RSEL_LOGIC; lfn = LG_NOR; end
      OP_ANDI:  begin rsel = RSEL_LOGIC; lfn = LG_AND; use_zimm = 1'b1; end
      OP_ORI:   begin rsel = RSEL_LOGIC; lfn = LG_OR;  use_zimm = 1'b1; end
      OP_XORI:  begin rsel = RSEL_LOGIC; lfn = LG_XOR; use_zimm = 1'b1; end
      OP_LUI:   rsel = RSEL_UPPER;
      OP_SLT:   begin rsel = RSEL_LESS; cmp_signed = 1'b1; end
      OP_SLTU:  rsel = RSEL_LESS;
      OP_SLTI:  begin rsel = RSEL_LESS; cmp_signed = 1'b1; use_simm = 1'b1; end
      OP_SLTIU: begin rsel = RSEL_LESS; use_simm = 1'b1; end
      OP_SLL:   begin rsel = RSEL_SHIFT; skind = SH_LEFT; end
      OP_SRL:   begin rsel = RSEL_SHIFT; skind = SH_RLOG; end
      OP_SRA:   begin rsel = RSEL_SHIFT; skind = SH_RARI; end
      OP_SLLV:  begin rsel = RSEL_SHIFT; skind = SH_LEFT; var_sh = 1'b1; end
      OP_SRLV:  begin rsel = RSEL_SHIFT; skind = SH_RLOG; var_sh = 1'b1; end
      OP_SRAV:  begin rsel = RSEL_SHIFT; skind = SH_RARI; var_sh = 1'b1; end
      OP_BEQ:   begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_EQ;  end
      OP_BNE:   begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_NE;  end
      OP_BGTZ:  begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_GTZ; end
      OP_BLEZ:  begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_LEZ; end
      OP_BGEZ:  begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_GEZ; end
      OP_BLTZ:  begin is_br = 1'b1; we_dec = 1'b0; bcond = BC_LTZ; end
      default:  begin we_dec = 1'b0; ill_dec = 1'b1; end
    endcase
  end

  // second operand selection
  logic [XLEN-1:0] src_b;
  assign src_b = use_simm ? imm_sext(imm) : use_zimm ? imm_zext(imm) : opb;

  logic [XLEN-1:0] arith_y, logic_y, shift_y;
  logic            ovf_evt, cond_true;
  logic [SHW-1:0]  sh_amt;

  assign sh_amt = var_sh ? opa[SHW-1:0] : shamt;

  exu_arith #(.XLEN(XLEN)) u_arith (
    .a(opa), .b(src_b), .do_sub(do_sub), .sum(arith_y), .ovf_evt(ovf_evt)
  );

  exu_logic #(.XLEN(XLEN)) u_logic (
    .a(opa), .b(src_b), .fn(lfn), .y(logic_y)
  );

  exu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
    .val(opb), .amt(sh_amt), .kind(skind), .y(shift_y)
  );

  exu_branch #(.XLEN(XLEN)) u_branch (
    .a(opa), .b(opb), .cond(bcond), .taken(cond_true)
  );

  // result assembly
  logic            trap_hit;
  logic [XLEN-1:0] raw_y;

  assign trap_hit = trap_en && ovf_evt;

  always_comb begin
    case (rsel)
      RSEL_ARITH: raw_y = arith_y;
      RSEL_LOGIC: raw_y = logic_y;
      RSEL_SHIFT: raw_y = shift_y;
      RSEL_LESS:  raw_y = {{(XLEN-1){1'b0}}, less_than(opa, src_b, cmp_signed)};
      RSEL_UPPER: raw_y = {imm, {EXTW{1'b0}}};
      default:    raw_y = '0;
    endcase
  end

  assign wr_en      = we_dec && !trap_hit;
  assign ovf_trap   = trap_hit;
  assign illegal_op = ill_dec;
  assign br_taken   = is_br && cond_true;
  assign result     = wr_en ? raw_y : '0;

  always_comb begin
    AST_TRAP_NO_WRITE: assert (!ovf_trap || !wr_en); // R1
    AST_ONE_OUTCOME: assert ($onehot0({wr_en, ovf_trap, illegal_op})); // R11
    AST_QUIET_RESULT: assert (wr_en || result == '0); // R11
    AST_UPPER_LOW_ZERO: assert (op_code != OP_LUI || result[EXTW-1:0] == '0); // R6
    AST_WRAP_NO_TRAP: assert (!(op_code == OP_ADDU || op_code == OP_SUBU ||
                                op_code == OP_ADDIU) || !ovf_trap); // R3
    AST_BRANCH_NO_WRITE: assert (!br_taken || !wr_en); // R10
  end
endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  import exu_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  op_code;
  logic [31:0] opa, opb, result;
  logic [15:0] imm;
  logic [4:0]  shamt;
  logic        wr_en, ovf_trap, illegal_op, br_taken;

  int_exec_unit u_int_exec_unit (
    .op_code(op_code), .opa(opa), .opb(opb), .imm(imm), .shamt(shamt),
    .result(result), .wr_en(wr_en), .ovf_trap(ovf_trap),
    .illegal_op(illegal_op), .br_taken(br_taken)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // expected outputs packed as {result, wr_en, ovf, ill, taken}
  function automatic logic [35:0] model(input logic [5:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [4:0] sh);
    longint sa, sb, wide;
    logic [31:0] se, ze, r;
    logic we, ov, il, tk;
    se = 32'(signed'(im));
    ze = {16'h0, im};
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    r = 0; we = 1; ov = 0; il = 0; tk = 0;
    case (op)
      1, 5: begin
        wide = sa + ((op == 1) ? sb : longint'(signed'(se)));
        if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin ov = 1; we = 0; end
        else r = wide[31:0];
      end
      3: begin
        wide = sa - sb;
        if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin ov = 1; we = 0; end
        else r = wide[31:0];
      end
      2: r = a + b;
      4: r = a - b;
      6: r = a + se;
      7: r = a & b;
      8: r = a | b;
      9: r = a ^ b;
      10: r = ~(a | b);
      11: r = a & ze;
      12: r = a | ze;
      13: r = a ^ ze;
      14: r = {im, 16'h0};
      15: r = {31'b0, sa < sb};
      16: r = {31'b0, a < b};
      17: r = {31'b0, sa < longint'(signed'(se))};
      18: r = {31'b0, a < se};
      19: r = b << sh;
      20: r = b >> sh;
      21: r = $signed(b) >>> sh;
      22: r = b << a[4:0];
      23: r = b >> a[4:0];
      24: r = $signed(b) >>> a[4:0];
      25: begin we = 0; tk = (a == b); end
      26: begin we = 0; tk = (a != b); end
      27: begin we = 0; tk = (sa > 0); end
      28: begin we = 0; tk = (sa <= 0); end
      29: begin we = 0; tk = (sa >= 0); end
      30: begin we = 0; tk = (sa < 0); end
      default: begin we = 0; il = 1; end
    endcase
    return {r, we, ov, il, tk};
  endfunction

  function automatic string req_of(input logic [5:0] op);
    if (op == 1 || op == 5) return "R1";
    if (op == 3) return "R2";
    if (op == 2 || op == 4 || op == 6) return "R3";
    if (op >= 7 && op <= 10) return "R4";
    if (op >= 11 && op <= 13) return "R5";
    if (op == 14) return "R6";
    if (op >= 15 && op <= 18) return "R7";
    if (op >= 19 && op <= 21) return "R8";
    if (op >= 22 && op <= 24) return "R9";
    if (op >= 25 && op <= 30) return "R10";
    return "R11";
  endfunction

  task automatic run_one(input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] im,
                         input logic [4:0] sh, input string tag);
    logic [35:0] exp_v, act_v;
    @(posedge clk);
    op_code = op; opa = a; opb = b; imm = im; shamt = sh;
    @(negedge clk);
    exp_v = model(op, a, b, im, sh);
    act_v = {result, wr_en, ovf_trap, illegal_op, br_taken};
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%h sh=%0d actual=%h expected=%h",
               tag, op, a, b, im, sh, act_v, exp_v);
    end
  endtask

  localparam int NV = 40;
  // {op, opa, opb, imm, shamt}
  localparam logic [90:0] VEC [NV] = '{
    {6'd1,  32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0},  // R1 positive overflow
    {6'd1,  32'h80000000, 32'h80000000, 16'h0000, 5'd0},  // R1 negative overflow
    {6'd1,  32'h7FFFFFFF, 32'h80000000, 16'h0000, 5'd0},  // R1 mixed signs
    {6'd1,  32'h00001234, 32'h00000F00, 16'h0000, 5'd0},
    {6'd5,  32'h7FFFFFF0, 32'h0, 16'h7FFF, 5'd0},          // R1 imm overflow
    {6'd5,  32'h00000010, 32'h0, 16'hFFF0, 5'd0},          // R1 negative imm
    {6'd5,  32'h80000000, 32'h0, 16'hFFFF, 5'd0},          // R1 imm underflow
    {6'd3,  32'h00000000, 32'h80000000, 16'h0, 5'd0},      // R2 overflow
    {6'd3,  32'h80000000, 32'h00000001, 16'h0, 5'd0},      // R2 overflow
    {6'd3,  32'h80000000, 32'hFFFFFFFF, 16'h0, 5'd0},      // R2 same sign
    {6'd3,  32'h00000005, 32'h00000009, 16'h0, 5'd0},
    {6'd2,  32'h7FFFFFFF, 32'h00000001, 16'h0, 5'd0},      // R3 wrap
    {6'd4,  32'h80000000, 32'h00000001, 16'h0, 5'd0},      // R3 wrap
    {6'd6,  32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0},          // R3
    {6'd6,  32'h00000000, 32'h0, 16'h8000, 5'd0},          // R3 sext
    {6'd7,  32'hF0F0A5A5, 32'hFF00FF00, 16'h0, 5'd0},      // R4
    {6'd8,  32'hF0F0A5A5, 32'h0F000F00, 16'h0, 5'd0},
    {6'd9,  32'hFFFF0000, 32'hF0F0F0F0, 16'h0, 5'd0},
    {6'd10, 32'h12345678, 32'h0000FFFF, 16'h0, 5'd0},
    {6'd11, 32'hFFFFFFFF, 32'hDEADBEEF, 16'h8421, 5'd0},   // R5 zero-extend
    {6'd12, 32'h00000000, 32'h0, 16'hFFFF, 5'd0},
    {6'd13, 32'hAAAAAAAA, 32'h0, 16'h8000, 5'd0},
    {6'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001, 5'd0},   // R6
    {6'd15, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0},      // R7 signed
    {6'd16, 32'hFFFFFFFF, 32'h00000001, 16'h0, 5'd0},      // R7 unsigned
    {6'd17, 32'hFFFFFF00, 32'h0, 16'hFFFF, 5'd0},          // R7
    {6'd18, 32'h7FFFFFFF, 32'h0, 16'hFFFF, 5'd0},          // R7 sext as unsigned
    {6'd18, 32'h00001000, 32'h0, 16'h0800, 5'd0},
    {6'd19, 32'h0, 32'h80000001, 16'h0, 5'd31},            // R8
    {6'd20, 32'h0, 32'h80000000, 16'h0, 5'd31},
    {6'd21, 32'h0, 32'h80000000, 16'h0, 5'd31},
    {6'd21, 32'h0, 32'h40000000, 16'h0, 5'd0},
    {6'd22, 32'hFFFFFFE4, 32'h00000003, 16'h0, 5'd9},      // R9 opa[4:0]=4
    {6'd23, 32'h00000025, 32'hF0000000, 16'h0, 5'd1},      // R9 amount 5
    {6'd24, 32'h8000003F, 32'h80000000, 16'h0, 5'd0},      // R9 amount 31
    {6'd25, 32'h00000007, 32'h00000007, 16'h0, 5'd0},      // R10
    {6'd27, 32'h80000000, 32'h0, 16'h0, 5'd0},
    {6'd28, 32'h00000000, 32'h0, 16'h0, 5'd0},
    {6'd0,  32'h11111111, 32'h22222222, 16'h1234, 5'd3},   // R11
    {6'd63, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31}
  };

  initial begin
    op_code = 6'd0; opa = '0; opb = '0; imm = '0; shamt = '0;
    // idle state: code 0 flags illegal with all outputs quiet (R11)
    @(negedge clk);
    n_checks++;
    if ({result, wr_en, ovf_trap, illegal_op, br_taken} !== {32'h0, 4'b0010}) begin
      n_fail++;
      $display("FAIL R11 idle actual=%h expected=%h",
               {result, wr_en, ovf_trap, illegal_op, br_taken}, {32'h0, 4'b0010});
    end
    for (int i = 0; i < NV; i++)
      run_one(VEC[i][90:85], VEC[i][84:53], VEC[i][52:21], VEC[i][20:5],
              VEC[i][4:0], req_of(VEC[i][90:85]));
    // directed corner cases
    run_one(6'd26, 32'h1, 32'h1, 16'h0, 5'd0, "R10");   // BNE not taken
    run_one(6'd29, 32'h0, 32'h0, 16'h0, 5'd0, "R10");   // BGEZ at zero
    run_one(6'd30, 32'hFFFFFFFF, 32'h0, 16'h0, 5'd0, "R10");
    run_one(6'd27, 32'h0, 32'h0, 16'h0, 5'd0, "R10");   // BGTZ at zero
    run_one(6'd31, 32'h1, 32'h1, 16'h1, 5'd1, "R11");
    run_one(6'd20, 32'h0, 32'hFFFFFFFF, 16'h0, 5'd0, "R8");
    run_one(6'd23, 32'hFFFFFFE0, 32'h12345678, 16'h0, 5'd7, "R9"); // amount 0
    run_one(6'd15, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, "R7");
    run_one(6'd16, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0, "R7");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule